// File: doc/BRIEF.md
# SDRAM Command Protocol Checker

This block watches the command bus of a single-data-rate SDRAM without driving anything. At every rising clock edge where the clock enable is high, it decodes the chip select, row strobe, column strobe and write enable into one command. It keeps a small state machine for each bank and checks the command against those states. Any command that breaks the ordering rules raises its own error bit for one cycle. A sticky flag keeps a record that at least one violation has happened since reset.

The checker also snoops mode-register loads to learn the programmed burst length. With that length it can tell when a read or write burst ends on its own. It follows bursts that are cut short by another bank's access, by a precharge or by a burst stop. It follows auto-precharge accesses into their precharge phase, and it freezes all of its tracking while the clock is suspended. The per-bank states are brought out as a packed vector so that surrounding verification code can inspect them.

Top module: `sdram_cmd_checker`

## Requirements
- R1: Command code {cs_n,ras_n,cas_n,we_n}: 0111 no-op, 0011 activate, 0101 read, 0100 write, 0110 burst stop, 0010 precharge (a10=1 means all banks), 0001 refresh, 0000 mode load. When cs_n is high the command is an inhibit: no error, and banks change only by their own countdowns.
- R2: Bank state codes on bank_state[3b+2:3b]: 0 idle, 1 row open, 2 reading, 3 writing, 4 reading with auto precharge, 5 writing with auto precharge, 6 precharging. An activate moves an idle bank to 1. An activate to a bank in state 1, 2, 3 or 6 sets err_pulse[3].
- R3: A read or write to a bank in state 0 or 6 sets err_pulse[0].
- R4: A read or write to a bank in state 1 enters 2 or 3, or 4 or 5 when a10 is high. It stays there for the burst length in clock edges. Then it returns to 1, or for 4/5 it enters 6. State 6 lasts PRE_CYC edges and then goes to 0.
- R5: A legal mode load takes mode_addr[2]=1 as a full-page burst, which ends only by command. Otherwise the burst length is 2^mode_addr[1:0]. After reset the burst length is 1.
- R6: Refresh or mode load while any bank is not idle sets err_pulse[1], and the burst length stays unchanged.
- R7: When a bank is in state 4 or 5, an activate, read, write or precharge to it sets err_pulse[2]. So does a precharge-all or a burst stop.
- R8: A read or write to another bank ends a running burst without error. A burst in 2 or 3 goes to 1, and a burst in 4 or 5 goes to 6.
- R9: In state 2 or 3, a precharge moves the bank to 6, a burst stop moves it to 1, and a new read or write to the same bank restarts the burst.
- R10: At an edge where cke is low, no command is evaluated, no error is raised, and all bank states and counters hold.
- R11: Each error bit is high for exactly the cycle after the offending edge. err_sticky rises with the first error and holds until reset.
- R12: A command that raises an error changes no bank state, and at most one error bit is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / precharge-all address bit |
| mode_addr | input | 3 | Low address bits carrying the burst length code |
| err_pulse | output | 4 | Per-violation error bits, one cycle |
| err_sticky | output | 1 | OR of all errors since reset |
| bank_state | output | 3*NUM_BANKS | Packed per-bank state codes |

## Verification
The assertions assume that the monitored bus is sampled on the same clock as the checker. They also assume that rst_n is held low for at least one edge before any command is judged. Some assertions claim that at most one bank bursts at a time. Those hold only because the checker itself ends the older burst whenever another bank starts one, so the stimulus can issue any command sequence. The sweep resets the checker before every trial so that no trial depends on an earlier one. It programs a full-page burst so that burst states hold still while a single command is judged.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;
  typedef enum logic [3:0] {
    CMD_INH, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
    CMD_BT, CMD_PRE, CMD_REF, CMD_LMR
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE = 3'd0, BK_ACT = 3'd1, BK_RD = 3'd2, BK_WR = 3'd3,
    BK_RDAP = 3'd4, BK_WRAP = 3'd5, BK_PRE = 3'd6
  } bank_st_e;

  localparam int ERR_NOROW  = 0;
  localparam int ERR_BUSY   = 1;
  localparam int ERR_APHOLD = 2;
  localparam int ERR_OPEN   = 3;
  localparam int NUM_ERR    = 4;
  localparam int ST_W       = 3;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_chk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) cmd = CMD_INH;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BT;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_LMR;
      endcase
    end
  end
endmodule

// File: rtl/sdram_burst_cfg.sv
module sdram_burst_cfg #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [2:0]       code,
  output logic [CNT_W-1:0] bl_len,
  output logic             bl_full
);
  logic [2:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    code_q <= 3'b000;
    else if (load) code_q <= code;
  end

  assign bl_len  = CNT_W'(1) << code_q[1:0];
  assign bl_full = code_q[2];
endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_chk_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int PRE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             accept,
  input  cmd_e             cmd,
  input  logic             sel,
  input  logic             a10,
  input  logic             other_rw,
  input  logic [CNT_W-1:0] bl_len,
  input  logic             bl_full,
  output bank_st_e         st
);
  localparam logic [CNT_W-1:0] PRE_LD = CNT_W'(PRE_CYC);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  bank_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             own_rw, pre_hit, is_ap;
  bank_st_e         burst_st;

  assign own_rw   = accept && sel && (cmd == CMD_RD || cmd == CMD_WR);
  assign pre_hit  = accept && cmd == CMD_PRE && (sel || a10);
  assign is_ap    = (st_q == BK_RDAP) || (st_q == BK_WRAP);
  assign burst_st = (cmd == CMD_RD) ? (a10 ? BK_RDAP : BK_RD)
                                    : (a10 ? BK_WRAP : BK_WR);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      BK_IDLE: if (accept && sel && cmd == CMD_ACT) st_d = BK_ACT;
      BK_ACT: begin
        if (own_rw) begin
          st_d  = burst_st;
          cnt_d = bl_len;
        end else if (pre_hit) begin
          st_d  = BK_PRE;
          cnt_d = PRE_LD;
        end
      end
      BK_RD, BK_WR, BK_RDAP, BK_WRAP: begin
        if (accept && other_rw) begin
          st_d  = is_ap ? BK_PRE : BK_ACT;
          cnt_d = PRE_LD;
        end else if (own_rw) begin
          st_d  = burst_st;
          cnt_d = bl_len;
        end else if (pre_hit) begin
          st_d  = BK_PRE;
          cnt_d = PRE_LD;
        end else if (accept && cmd == CMD_BT) begin
          st_d = BK_ACT;
        end else if (!bl_full) begin
          if (cnt_q <= ONE) begin
            st_d  = is_ap ? BK_PRE : BK_ACT;
            cnt_d = PRE_LD;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      end
      BK_PRE: begin
        if (cnt_q <= ONE) st_d = BK_IDLE;
        else cnt_d = cnt_q - ONE;
      end
      default: st_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else if (run) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st = st_q;

  a_r4_no_direct_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != BK_IDLE && st_q != BK_PRE) |=> (st_q != BK_IDLE));

  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(st_q) && $stable(cnt_q)));

  a_r7_rdap_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_RDAP) |=> (st_q == BK_RDAP || st_q == BK_PRE));

  a_r7_wrap_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_WRAP) |=> (st_q == BK_WRAP || st_q == BK_PRE));
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int PRE_CYC   = 2,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W    = ($clog2(PRE_CYC + 1) > 4) ? $clog2(PRE_CYC + 1) : 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cke,
  input  logic                      cs_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic [BA_W-1:0]           ba,
  input  logic                      a10,
  input  logic [2:0]                mode_addr,
  output logic [NUM_ERR-1:0]        err_pulse,
  output logic                      err_sticky,
  output logic [ST_W*NUM_BANKS-1:0] bank_state
);
  cmd_e                 cmd;
  bank_st_e             st [NUM_BANKS];
  logic [NUM_BANKS-1:0] is_idle, is_ap, in_burst;
  logic [NUM_ERR-1:0]   err_d;
  logic                 accept, sel_ap, all_idle, any_ap, is_rw;
  bank_st_e             st_sel;
  logic [CNT_W-1:0]     bl_len;
  logic                 bl_full;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  sdram_burst_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .load(cke && accept && cmd == CMD_LMR),
    .code(mode_addr), .bl_len(bl_len), .bl_full(bl_full)
  );

  assign is_rw = (cmd == CMD_RD) || (cmd == CMD_WR);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_bank_fsm #(.CNT_W(CNT_W), .PRE_CYC(PRE_CYC)) u_bank (
      .clk(clk), .rst_n(rst_n), .run(cke), .accept(accept), .cmd(cmd),
      .sel(ba == BA_W'(b)), .a10(a10),
      .other_rw(is_rw && ba != BA_W'(b)),
      .bl_len(bl_len), .bl_full(bl_full), .st(st[b])
    );
    assign is_idle[b]  = (st[b] == BK_IDLE);
    assign is_ap[b]    = (st[b] == BK_RDAP) || (st[b] == BK_WRAP);
    assign in_burst[b] = (st[b] == BK_RD) || (st[b] == BK_WR) || is_ap[b];
    assign bank_state[b*ST_W +: ST_W] = st[b];
  end

  assign st_sel   = st[ba];
  assign sel_ap   = (st_sel == BK_RDAP) || (st_sel == BK_WRAP);
  assign all_idle = &is_idle;
  assign any_ap   = |is_ap;

  always_comb begin
    err_d = '0;
    if (cke) begin
      case (cmd)
        CMD_ACT: begin
          if (sel_ap) err_d[ERR_APHOLD] = 1'b1;
          else if (st_sel != BK_IDLE) err_d[ERR_OPEN] = 1'b1;
        end
        CMD_RD, CMD_WR: begin
          if (sel_ap) err_d[ERR_APHOLD] = 1'b1;
          else if (st_sel == BK_IDLE || st_sel == BK_PRE) err_d[ERR_NOROW] = 1'b1;
        end
        CMD_PRE: if (a10 ? any_ap : sel_ap) err_d[ERR_APHOLD] = 1'b1;
        CMD_BT:  if (any_ap) err_d[ERR_APHOLD] = 1'b1;
        CMD_REF, CMD_LMR: if (!all_idle) err_d[ERR_BUSY] = 1'b1;
        default: ;
      endcase
    end
  end

  assign accept = ~|err_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse  <= '0;
      err_sticky <= 1'b0;
    end else begin
      err_pulse  <= err_d;
      err_sticky <= err_sticky | (|err_d);
    end
  end

  a_r11_sticky_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |-> err_sticky);

  a_r11_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  a_r1_inhibit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (err_pulse == '0));

  a_r10_suspend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (err_pulse == '0));

  a_r12_one_error: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_pulse));

  a_r8_single_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_burst) <= 1);
endmodule

// File: tb/test_sdram_cmd_checker.sv
module test_sdram_cmd_checker;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [0:0] ba;
  logic [2:0] mode_addr;
  logic [3:0] err_pulse;
  logic       err_sticky;
  logic [5:0] bank_state;
  int checks = 0;
  int errors = 0;

  localparam logic [3:0] C_INH = 4'b1000, C_NOP = 4'b0111, C_ACT = 4'b0011,
    C_RD = 4'b0101, C_WR = 4'b0100, C_BT = 4'b0110, C_PRE = 4'b0010,
    C_REF = 4'b0001, C_LMR = 4'b0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_checker i_sdram_cmd_checker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .mode_addr(mode_addr),
    .err_pulse(err_pulse), .err_sticky(err_sticky), .bank_state(bank_state)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] c, input logic b, input logic a, input logic [2:0] m);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b; a10 = a; mode_addr = m;
    @(posedge clk); #1;
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cke = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
    ba = 1'b0; a10 = 1'b0; mode_addr = 3'b000;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  function automatic logic [3:0] code_of(input int c);
    case (c)
      0: return C_INH; 1: return C_NOP; 2: return C_ACT; 3: return C_RD;
      4: return C_WR;  5: return C_BT;  6: return C_PRE; 7: return C_REF;
      default: return C_LMR;
    endcase
  endfunction

  // s: 0 idle, 1 open, 2 reading, 3 reading+AP, 4 precharging
  function automatic int exp_err(input int s, input int c);
    case (c)
      2: return (s == 3) ? 4 : ((s != 0) ? 8 : 0);
      3, 4: return (s == 3) ? 4 : ((s == 0 || s == 4) ? 1 : 0);
      5, 6: return (s == 3) ? 4 : 0;
      7, 8: return (s != 0) ? 2 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_st(input int s, input int c, input int a);
    int base;
    base = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 2 : (s == 3) ? 4 : 6;
    if (exp_err(s, c) != 0) return base;
    case (c)
      2: return (s == 0) ? 1 : base;
      3: return (a != 0) ? 4 : 2;
      4: return (a != 0) ? 5 : 3;
      5: return (s == 2) ? 1 : base;
      6: return (s == 1 || s == 2) ? 6 : base;
      default: return base;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R11 reset err", int'(err_pulse), 0);
    chk("R11 reset sticky", int'(err_sticky), 0);
    chk("R2 reset state", int'(bank_state), 0);

    // Sweep R1 R2 R3 R6 R7 R9 R12: every command against every bank-0 setup
    for (int s = 0; s < 5; s++) begin
      for (int c = 0; c < 9; c++) begin
        for (int a = 0; a < 2; a++) begin
          do_reset();
          send(C_LMR, 1'b0, 1'b0, 3'b100);
          if (s != 0) send(C_ACT, 1'b0, 1'b0, 3'b100);
          if (s == 2) send(C_RD, 1'b0, 1'b0, 3'b100);
          if (s == 3) send(C_RD, 1'b0, 1'b1, 3'b100);
          if (s == 4) send(C_PRE, 1'b0, 1'b0, 3'b100);
          send(code_of(c), 1'b0, 1'(a), 3'b100);
          chk($sformatf("R12 sweep err s%0d c%0d a%0d", s, c, a), int'(err_pulse), exp_err(s, c));
          chk($sformatf("R2 sweep st s%0d c%0d a%0d", s, c, a), int'(bank_state[2:0]), exp_st(s, c, a));
          chk($sformatf("R1 sweep b1 s%0d c%0d a%0d", s, c, a), int'(bank_state[5:3]), 0);
        end
      end
    end

    // R5: reset burst length is one
    do_reset();
    send(C_ACT, 1'b0, 1'b0, 3'b000);
    send(C_RD, 1'b0, 1'b0, 3'b000);
    chk("R5 bl1 reading", int'(bank_state[2:0]), 2);
    send(C_NOP, 1'b0, 1'b0, 3'b000);
    chk("R5 bl1 done", int'(bank_state[2:0]), 1);

    // R4 R5: burst of four with auto precharge, then precharge countdown
    do_reset();
    send(C_LMR, 1'b0, 1'b0, 3'b010);
    send(C_ACT, 1'b0, 1'b0, 3'b000);
    send(C_RD, 1'b0, 1'b1, 3'b000);
    for (int i = 0; i < 3; i++) begin
      chk("R4 bl4 ap burst", int'(bank_state[2:0]), 4);
      send(C_NOP, 1'b0, 1'b0, 3'b000);
    end
    chk("R4 bl4 last beat", int'(bank_state[2:0]), 4);
    send(C_NOP, 1'b0, 1'b0, 3'b000);
    chk("R4 ap to precharge", int'(bank_state[2:0]), 6);
    send(C_NOP, 1'b0, 1'b0, 3'b000);
    chk("R4 precharge hold", int'(bank_state[2:0]), 6);
    send(C_NOP, 1'b0, 1'b0, 3'b000);
    chk("R4 precharge idle", int'(bank_state[2:0]), 0);

    // R10: clock suspend freezes the burst count
    do_reset();
    send(C_LMR, 1'b0, 1'b0, 3'b010);
    send(C_ACT, 1'b0, 1'b0, 3'b000);
    send(C_RD, 1'b0, 1'b0, 3'b000);
    send(C_NOP, 1'b0, 1'b0, 3'b000);
    cke = 1'b0;
    send(C_ACT, 1'b0, 1'b0, 3'b000);
    send(C_REF, 1'b1, 1'b0, 3'b000);
    chk("R10 suspend state", int'(bank_state), 2);
    chk("R10 suspend no err", int'(err_pulse), 0);
    cke = 1'b1;
    send(C_NOP, 1'b0, 1'b0, 3'b000);
    send(C_NOP, 1'b0, 1'b0, 3'b000);
    chk("R10 resumed count", int'(bank_state[2:0]), 2);
    send(C_NOP, 1'b0, 1'b0, 3'b000);
    chk("R10 resumed end", int'(bank_state[2:0]), 1);

    // R8: access to other bank during auto-precharge burst
    do_reset();
    send(C_LMR, 1'b0, 1'b0, 3'b010);
    send(C_ACT, 1'b0, 1'b0, 3'b000);
    send(C_ACT, 1'b1, 1'b0, 3'b000);
    send(C_RD, 1'b0, 1'b1, 3'b000);
    send(C_WR, 1'b1, 1'b0, 3'b000);
    chk("R8 concurrent ap no err", int'(err_pulse), 0);
    chk("R8 ap bank precharges", int'(bank_state[2:0]), 6);
    chk("R8 other bank writes", int'(bank_state[5:3]), 3);

    // R8: read on bank 1 interrupts write on bank 0
    do_reset();
    send(C_LMR, 1'b0, 1'b0, 3'b100);
    send(C_ACT, 1'b0, 1'b0, 3'b000);
    send(C_ACT, 1'b1, 1'b0, 3'b000);
    send(C_WR, 1'b0, 1'b0, 3'b000);
    send(C_RD, 1'b1, 1'b0, 3'b000);
    chk("R8 interrupt no err", int'(err_pulse), 0);
    chk("R8 write bank reopens", int'(bank_state[2:0]), 1);
    chk("R8 read bank reads", int'(bank_state[5:3]), 2);

    // R11: pulse lasts one cycle, sticky holds
    do_reset();
    send(C_RD, 1'b0, 1'b0, 3'b000);
    chk("R11 pulse", int'(err_pulse), 1);
    chk("R11 sticky set", int'(err_sticky), 1);
    send(C_NOP, 1'b0, 1'b0, 3'b000);
    chk("R11 pulse clears", int'(err_pulse), 0);
    chk("R11 sticky holds", int'(err_sticky), 1);

    // R6: rejected mode load keeps burst length one
    do_reset();
    send(C_ACT, 1'b0, 1'b0, 3'b000);
    send(C_LMR, 1'b0, 1'b0, 3'b100);
    chk("R6 busy err", int'(err_pulse), 2);
    send(C_RD, 1'b0, 1'b0, 3'b000);
    send(C_NOP, 1'b0, 1'b0, 3'b000);
    chk("R6 mode unchanged", int'(bank_state[2:0]), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule